// File: doc/BRIEF.md
# Data-Move and Stack Memory Unit

This unit retires the data-movement group of a small 32-bit processor core. The issue stage hands it a 3-bit operation, an immediate flag, the 5-bit second-register field, the destination index, three operand values (A, B and C) and the current stack-pointer value. When the immediate flag is set, the operand used as C is the low 16 bits of the C input, zero-extended. The unit decides whether the operation needs memory. It then drives a 16-bit-address, 32-bit-data memory port with a request/ready handshake. It ends each operation with a single retire cycle that carries a register write request, a stack-pointer update and an exception request with its code.

The control is a four-state machine. IDLE waits for `issue_valid`. From IDLE it moves to ACCESS for load, store, push and pop, to TRAP_WAIT for the software interrupt, and straight to RETIRE for every other operation. ACCESS holds the request until `mem_ready` is seen at a clock edge and then moves to RETIRE. TRAP_WAIT always moves to RETIRE after one cycle. RETIRE always returns to IDLE. An issue is accepted only in IDLE, and `busy` is high in every other state.

Opcode encoding: 0 move, 1 move-high, 2 load, 3 store, 4 push, 5 pop, 6 extended read (unimplemented), 7 software interrupt. The stack grows upward. A push stores and then increments the pointer. A pop decrements the pointer and then reads.

Top module: `dmu_top`

## Requirements
- R1: Opcode 0 with the immediate flag clear writes C to the destination. `done` and the write appear in the cycle after the issue edge.
- R2: Opcode 0 with the immediate flag set writes the 16-bit immediate plus the 5-bit second-register field shifted left by 16.
- R3: Opcode 1 writes C shifted left by 16 to the destination.
- R4: Opcode 2 reads memory at (B + C) modulo 2^16 with the write enable low, and writes the returned data to the destination.
- R5: Opcode 3 writes A to memory at (B + C) modulo 2^16 with the write enable high, and requests no register write.
- R6: Opcode 4 writes C to the address given by the low 16 bits of the stack pointer, and updates the stack pointer to its value plus 1.
- R7: Opcode 5 reads from (stack pointer − 1) modulo 2^16, writes the data to the destination, and updates the stack pointer to its value minus 1.
- R8: Opcode 6 requests exception code 258. It makes no register write and no memory access.
- R9: Opcode 7 requests an exception whose code is C. It retires two cycles after the issue edge, one cycle later than a move.
- R10: A destination index of 0 never produces a register write. Any stack-pointer update and memory access still take place.
- R11: A memory request holds its address, data and direction until `mem_ready` is high at a clock edge. The operation retires in the next cycle, and only then does the register write appear.
- R12: `done` is a one-cycle pulse and `busy` is low after it. An `issue_valid` seen while busy is ignored. Reset leaves every request output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Operation offered this cycle |
| op_code | input | 3 | Operation (encoding in R1–R9 text) |
| imm_flag | input | 1 | C is the zero-extended 16-bit immediate |
| rb_field | input | 5 | Second-register field, folded by immediate move |
| dest_idx | input | 5 | Destination register index |
| opnd_a | input | 32 | Operand A (store data) |
| opnd_b | input | 32 | Operand B (address base) |
| opnd_c | input | 32 | Operand C or immediate |
| sp_value | input | 32 | Current stack pointer (register 14) |
| busy | output | 1 | Operation in flight |
| done | output | 1 | Retire pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write direction |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory completes the request |
| mem_rdata | input | 32 | Memory read data |
| wr_en | output | 1 | Destination write request |
| wr_idx | output | 5 | Destination index |
| wr_data | output | 32 | Destination value |
| sp_wr_en | output | 1 | Stack-pointer update request |
| sp_wr_data | output | 32 | New stack pointer |
| exc_req | output | 1 | Exception request |
| exc_code | output | 32 | Exception code |

## Verification
The hardest state to reach from the ports is a second `issue_valid` arriving while a memory access is stalled, because it only exists when the bench itself holds `mem_ready` low. The bench draws a ready delay of zero to several cycles for each access and, on a random subset of accesses, offers a conflicting move in the middle of the stall. It then confirms that only the original operation retires. Directed cases add address wrap in B + C, a pop from stack pointer 0 that must read 0xFFFF, and a maximal folded immediate.

// File: rtl/dmu_pkg.sv
package dmu_pkg;

    typedef enum logic [2:0] {
        OP_MOV   = 3'd0,
        OP_MOVHI = 3'd1,
        OP_LOAD  = 3'd2,
        OP_STORE = 3'd3,
        OP_PUSH  = 3'd4,
        OP_POP   = 3'd5,
        OP_RDX   = 3'd6,
        OP_TRAP  = 3'd7
    } dm_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_TRAP_WAIT,
        ST_RETIRE
    } dm_state_e;

    function automatic logic op_uses_mem(input dm_op_e op);
        return (op == OP_LOAD) || (op == OP_STORE) ||
               (op == OP_PUSH) || (op == OP_POP);
    endfunction

endpackage

// File: rtl/dmu_fsm.sv
module dmu_fsm
    import dmu_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      issue_valid,
    input  dm_op_e    issue_op,
    input  logic      mem_ready,
    output dm_state_e state
);

    dm_state_e state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (issue_valid) begin
                    if (op_uses_mem(issue_op)) begin
                        state_nxt = ST_ACCESS;
                    end else if (issue_op == OP_TRAP) begin
                        state_nxt = ST_TRAP_WAIT;
                    end else begin
                        state_nxt = ST_RETIRE;
                    end
                end
            end
            ST_ACCESS: begin
                if (mem_ready) begin
                    state_nxt = ST_RETIRE;
                end
            end
            ST_TRAP_WAIT: state_nxt = ST_RETIRE;
            ST_RETIRE:    state_nxt = ST_IDLE;
            default:      state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

endmodule

// File: rtl/dmu_agu.sv
module dmu_agu
    import dmu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  dm_op_e              op,
    input  logic [DATA_W-1:0]   a_val,
    input  logic [DATA_W-1:0]   b_val,
    input  logic [DATA_W-1:0]   c_val,
    input  logic [DATA_W-1:0]   sp_val,
    output logic [ADDR_W-1:0]   addr,
    output logic [DATA_W-1:0]   wdata,
    output logic                we
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    always_comb begin
        addr  = ADDR_W'(b_val + c_val);
        wdata = '0;
        we    = 1'b0;
        unique case (op)
            OP_LOAD: begin
                addr = ADDR_W'(b_val + c_val);
            end
            OP_STORE: begin
                addr  = ADDR_W'(b_val + c_val);
                wdata = a_val;
                we    = 1'b1;
            end
            OP_PUSH: begin
                addr  = ADDR_W'(sp_val);
                wdata = c_val;
                we    = 1'b1;
            end
            OP_POP: begin
                addr = ADDR_W'(sp_val - ONE);
            end
            default: begin
                addr  = ADDR_W'(b_val + c_val);
                wdata = '0;
                we    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dmu_wb.sv
module dmu_wb
    import dmu_pkg::*;
#(
    parameter int          DATA_W      = 32,
    parameter int          IDX_W       = 5,
    parameter int          IMM_W       = 16,
    parameter int unsigned UNIMPL_CODE = 258
) (
    input  logic              retire,
    input  dm_op_e            op,
    input  logic              imm,
    input  logic [IDX_W-1:0]  rb,
    input  logic [IDX_W-1:0]  dest,
    input  logic [DATA_W-1:0] c_val,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] sp_val,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              sp_wr_en,
    output logic [DATA_W-1:0] sp_wr_data,
    output logic              exc_req,
    output logic [DATA_W-1:0] exc_code
);

    localparam logic [DATA_W-1:0] ONE    = DATA_W'(1);
    localparam logic [DATA_W-1:0] UNIMPL = DATA_W'(UNIMPL_CODE);

    logic [DATA_W-1:0] folded;
    logic              wants_wr;
    logic              wants_sp;
    logic              wants_exc;

    assign folded = c_val + (DATA_W'(rb) << IMM_W);

    always_comb begin
        wants_wr   = 1'b0;
        wants_sp   = 1'b0;
        wants_exc  = 1'b0;
        wr_data    = '0;
        sp_wr_data = '0;
        exc_code   = '0;
        unique case (op)
            OP_MOV: begin
                wants_wr = 1'b1;
                wr_data  = imm ? folded : c_val;
            end
            OP_MOVHI: begin
                wants_wr = 1'b1;
                wr_data  = c_val << IMM_W;
            end
            OP_LOAD: begin
                wants_wr = 1'b1;
                wr_data  = rdata;
            end
            OP_STORE: begin
                wants_wr = 1'b0;
            end
            OP_PUSH: begin
                wants_sp   = 1'b1;
                sp_wr_data = sp_val + ONE;
            end
            OP_POP: begin
                wants_wr   = 1'b1;
                wr_data    = rdata;
                wants_sp   = 1'b1;
                sp_wr_data = sp_val - ONE;
            end
            OP_RDX: begin
                wants_exc = 1'b1;
                exc_code  = UNIMPL;
            end
            OP_TRAP: begin
                wants_exc = 1'b1;
                exc_code  = c_val;
            end
            default: begin
                wants_wr = 1'b0;
            end
        endcase
    end

    // Register 0 is hard-wired: its write requests are dropped (R10)
    assign wr_en    = retire && wants_wr && (dest != '0);
    assign wr_idx   = dest;
    assign sp_wr_en = retire && wants_sp;
    assign exc_req  = retire && wants_exc;

endmodule

// File: rtl/dmu_top.sv
module dmu_top
    import dmu_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int          DATA_W      = 32,
    parameter int          IDX_W       = 5,
    parameter int          IMM_W       = 16,
    parameter int unsigned UNIMPL_CODE = 258
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [2:0]        op_code,
    input  logic              imm_flag,
    input  logic [IDX_W-1:0]  rb_field,
    input  logic [IDX_W-1:0]  dest_idx,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] opnd_c,
    input  logic [DATA_W-1:0] sp_value,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              sp_wr_en,
    output logic [DATA_W-1:0] sp_wr_data,
    output logic              exc_req,
    output logic [DATA_W-1:0] exc_code
);

    dm_state_e         state;
    dm_op_e            issue_op;
    logic              accept;
    logic [DATA_W-1:0] c_eff;

    dm_op_e            op_q;
    logic              imm_q;
    logic [IDX_W-1:0]  rb_q;
    logic [IDX_W-1:0]  dest_q;
    logic [DATA_W-1:0] a_q;
    logic [DATA_W-1:0] b_q;
    logic [DATA_W-1:0] c_q;
    logic [DATA_W-1:0] sp_q;
    logic [DATA_W-1:0] rd_q;

    logic              agu_we;
    logic              retire;

    assign issue_op = dm_op_e'(op_code);
    assign accept   = issue_valid && (state == ST_IDLE);
    assign c_eff    = imm_flag ? DATA_W'(opnd_c[IMM_W-1:0]) : opnd_c;

    dmu_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_valid (issue_valid),
        .issue_op    (issue_op),
        .mem_ready   (mem_ready),
        .state       (state)
    );

    // Operation capture on acceptance, read data capture on handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_MOV;
            imm_q  <= 1'b0;
            rb_q   <= '0;
            dest_q <= '0;
            a_q    <= '0;
            b_q    <= '0;
            c_q    <= '0;
            sp_q   <= '0;
            rd_q   <= '0;
        end else begin
            if (accept) begin
                op_q   <= issue_op;
                imm_q  <= imm_flag;
                rb_q   <= rb_field;
                dest_q <= dest_idx;
                a_q    <= opnd_a;
                b_q    <= opnd_b;
                c_q    <= c_eff;
                sp_q   <= sp_value;
            end
            if ((state == ST_ACCESS) && mem_ready) begin
                rd_q <= mem_rdata;
            end
        end
    end

    dmu_agu #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_agu (
        .op     (op_q),
        .a_val  (a_q),
        .b_val  (b_q),
        .c_val  (c_q),
        .sp_val (sp_q),
        .addr   (mem_addr),
        .wdata  (mem_wdata),
        .we     (agu_we)
    );

    // State-decoded outputs
    always_comb begin
        busy    = 1'b1;
        done    = 1'b0;
        mem_req = 1'b0;
        retire  = 1'b0;
        unique case (state)
            ST_IDLE:      busy = 1'b0;
            ST_ACCESS:    mem_req = 1'b1;
            ST_TRAP_WAIT: busy = 1'b1;
            ST_RETIRE: begin
                done   = 1'b1;
                retire = 1'b1;
            end
            default:      busy = 1'b1;
        endcase
        mem_we = mem_req && agu_we;
    end

    dmu_wb #(
        .DATA_W      (DATA_W),
        .IDX_W       (IDX_W),
        .IMM_W       (IMM_W),
        .UNIMPL_CODE (UNIMPL_CODE)
    ) u_wb (
        .retire     (retire),
        .op         (op_q),
        .imm        (imm_q),
        .rb         (rb_q),
        .dest       (dest_q),
        .c_val      (c_q),
        .rdata      (rd_q),
        .sp_val     (sp_q),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .sp_wr_en   (sp_wr_en),
        .sp_wr_data (sp_wr_data),
        .exc_req    (exc_req),
        .exc_code   (exc_code)
    );

endmodule

// File: rtl/dmu_checker.sv
module dmu_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue_valid,
    input logic [2:0]        op_code,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ready,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic              sp_wr_en,
    input logic              exc_req
);

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                     $stable(mem_wdata) && $stable(mem_we)));

    p_commit_after_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(mem_req)) |-> $past(mem_ready));

    p_no_zero_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx != '0));

    p_trap_extra_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !busy && (op_code == 3'd7)) |=> (busy && !done));

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !busy) |=> busy);

    p_side_effects_at_retire_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || sp_wr_en || exc_req) |-> done);

    p_no_req_when_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (busy && !done));

endmodule

bind dmu_top dmu_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .op_code     (op_code),
    .busy        (busy),
    .done        (done),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ready   (mem_ready),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .sp_wr_en    (sp_wr_en),
    .exc_req     (exc_req)
);

// File: tb/tb_dmu_top.sv
`timescale 1ns/1ps
module tb_dmu_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic        imm_flag = 1'b0;
    logic [4:0]  rb_field = '0;
    logic [4:0]  dest_idx = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] opnd_c = '0;
    logic [31:0] sp_value = '0;
    logic        busy, done, mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        wr_en, sp_wr_en, exc_req;
    logic [4:0]  wr_idx;
    logic [31:0] wr_data, sp_wr_data, exc_code;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit ended = 1'b0;

    always #2 clk = ~clk;

    dmu_top dut (
        .clk (clk), .rst_n (rst_n), .issue_valid (issue_valid),
        .op_code (op_code), .imm_flag (imm_flag), .rb_field (rb_field),
        .dest_idx (dest_idx), .opnd_a (opnd_a), .opnd_b (opnd_b),
        .opnd_c (opnd_c), .sp_value (sp_value), .busy (busy), .done (done),
        .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
        .mem_wdata (mem_wdata), .mem_ready (mem_ready), .mem_rdata (mem_rdata),
        .wr_en (wr_en), .wr_idx (wr_idx), .wr_data (wr_data),
        .sp_wr_en (sp_wr_en), .sp_wr_data (sp_wr_data),
        .exc_req (exc_req), .exc_code (exc_code)
    );

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
            finish_run();
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] op, input logic im);
        case (op)
            3'd0:    return im ? "R2" : "R1";
            3'd1:    return "R3";
            3'd2:    return "R4";
            3'd3:    return "R5";
            3'd4:    return "R6";
            3'd5:    return "R7";
            3'd6:    return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic run_op(input logic [2:0] op, input logic im, input logic [4:0] rb,
                          input logic [4:0] dst, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] c, input logic [31:0] sp, input int dly,
                          input logic [31:0] rd, input bit poke);
        logic [31:0] ce;
        logic        e_mem, e_we, e_wr, e_sp, e_exc;
        logic [15:0] e_addr;
        logic [31:0] e_wd, e_rv, e_spv, e_code;
        int          e_lat;
        string       rq;
        logic        g_mem, g_we, g_wr, g_sp, g_exc;
        logic [15:0] g_addr;
        logic [31:0] g_wd, g_rv, g_spv, g_code;
        logic [4:0]  g_idx;
        int          lat, waited;
        bit          poked;

        rq = req_of(op, im);
        ce = im ? {16'h0, c[15:0]} : c;
        e_mem = (op >= 3'd2) && (op <= 3'd5);
        e_we  = (op == 3'd3) || (op == 3'd4);
        case (op)
            3'd4:    e_addr = sp[15:0];
            3'd5:    e_addr = 16'(sp - 32'd1);
            default: e_addr = 16'(b + c);
        endcase
        if (op == 3'd2 || op == 3'd3) e_addr = 16'(b + ce);
        e_wd = (op == 3'd3) ? a : ((op == 3'd4) ? ce : 32'h0);
        e_wr = ((op <= 3'd2) || (op == 3'd5)) && (dst != 5'd0);
        case (op)
            3'd0:    e_rv = im ? (ce + {11'h0, rb, 16'h0}) : ce;
            3'd1:    e_rv = ce << 16;
            default: e_rv = rd;
        endcase
        e_sp   = (op == 3'd4) || (op == 3'd5);
        e_spv  = (op == 3'd4) ? sp + 32'd1 : sp - 32'd1;
        e_exc  = (op == 3'd6) || (op == 3'd7);
        e_code = (op == 3'd6) ? 32'd258 : ce;
        e_lat  = e_mem ? 2 + dly : ((op == 3'd7) ? 2 : 1);

        @(negedge clk);
        issue_valid = 1'b1; op_code = op; imm_flag = im; rb_field = rb;
        dest_idx = dst; opnd_a = a; opnd_b = b; opnd_c = c; sp_value = sp;
        g_mem = 0; g_we = 0; g_addr = '0; g_wd = '0;
        lat = 0; waited = 0; poked = 0;
        g_wr = 0; g_sp = 0; g_exc = 0; g_rv = '0; g_spv = '0; g_code = '0; g_idx = '0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            lat++;
            issue_valid = 1'b0;
            mem_ready   = 1'b0;
            if (done) begin
                g_wr = wr_en; g_idx = wr_idx; g_rv = wr_data;
                g_sp = sp_wr_en; g_spv = sp_wr_data;
                g_exc = exc_req; g_code = exc_code;
                break;
            end
            if (mem_req) begin
                g_mem = 1; g_we = mem_we; g_addr = mem_addr; g_wd = mem_wdata;
                if (poke && !poked) begin
                    // conflicting move offered while busy (R12)
                    poked = 1; issue_valid = 1'b1; op_code = 3'd0; imm_flag = 1'b0;
                    dest_idx = 5'd9; opnd_c = 32'hDEAD_BEEF;
                end
                if (waited == dly) begin
                    mem_ready = 1'b1;
                    mem_rdata = rd;
                end else begin
                    waited++;
                end
            end
        end
        chk(e_mem ? "R11" : rq, "latency", lat, e_lat);
        chk(rq, "mem access", {31'h0, g_mem}, {31'h0, e_mem});
        if (e_mem) begin
            chk(rq, "mem dir", {31'h0, g_we}, {31'h0, e_we});
            chk(rq, "mem addr", {16'h0, g_addr}, {16'h0, e_addr});
            if (e_we) chk(rq, "mem data", g_wd, e_wd);
        end
        chk((dst == 5'd0) ? "R10" : rq, "wr_en", {31'h0, g_wr}, {31'h0, e_wr});
        if (e_wr) begin
            chk(rq, "wr_idx", {27'h0, g_idx}, {27'h0, dst});
            chk(rq, "wr_data", g_rv, e_rv);
        end
        chk(rq, "sp_wr_en", {31'h0, g_sp}, {31'h0, e_sp});
        if (e_sp) chk(rq, "sp_wr_data", g_spv, e_spv);
        chk(rq, "exc_req", {31'h0, g_exc}, {31'h0, e_exc});
        if (e_exc) chk(rq, "exc_code", g_code, e_code);
        @(negedge clk);
        // after retire: no second done, back to idle, poked move ignored (R12)
        chk("R12", "post-retire done/busy/wr", {29'h0, done, busy, wr_en}, 32'h0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk("R12", "reset busy/done/req/wr/sp/exc",
            {26'h0, busy, done, mem_req, wr_en, sp_wr_en, exc_req}, 32'h0);
        rst_n = 1'b1;

        // directed corners
        run_op(3'd0, 1'b0, 5'd3, 5'd4, 0, 0, 32'hCAFE_F00D, 0, 0, 0, 0);        // R1
        run_op(3'd0, 1'b1, 5'h1F, 5'd5, 0, 0, 32'hABCD_FFFF, 0, 0, 0, 0);       // R2 max fold
        run_op(3'd1, 1'b0, 5'd0, 5'd6, 0, 0, 32'h1234_5678, 0, 0, 0, 0);        // R3
        run_op(3'd2, 1'b0, 5'd0, 5'd7, 0, 32'h0000_FFFF, 32'd2, 0, 1, 32'h1111_2222, 0); // R4 wrap
        run_op(3'd3, 1'b1, 5'd0, 5'd8, 32'h5A5A_A5A5, 32'h0003_0010, 32'h0000_0020, 0, 5, 0, 0); // R5
        run_op(3'd4, 1'b0, 5'd0, 5'd0, 0, 0, 32'h7777_0001, 32'h0001_FFFF, 0, 0, 0); // R6
        run_op(3'd5, 1'b0, 5'd0, 5'd2, 0, 0, 0, 32'h0, 2, 32'h0BAD_CAFE, 0);   // R7 wrap to FFFF
        run_op(3'd6, 1'b0, 5'd0, 5'd2, 0, 0, 0, 0, 0, 0, 0);                    // R8
        run_op(3'd7, 1'b1, 5'd0, 5'd2, 0, 0, 32'hFFFF_0042, 0, 0, 0, 0);        // R9
        run_op(3'd2, 1'b0, 5'd0, 5'd0, 0, 32'h10, 32'h20, 0, 0, 32'h9999_9999, 0); // R10
        run_op(3'd5, 1'b0, 5'd0, 5'd0, 0, 0, 0, 32'h40, 0, 32'h1, 0);           // R10 pop to r0
        run_op(3'd2, 1'b0, 5'd0, 5'd3, 0, 32'h100, 32'h4, 0, 3, 32'h3333_4444, 1); // R12 poke

        for (int i = 0; i < 400; i++) begin
            logic [2:0]  op;
            logic [31:0] sp;
            op = 3'($urandom);
            sp = ($urandom % 4 == 0) ? 32'($urandom % 2) : $urandom;
            run_op(op, 1'($urandom), 5'($urandom),
                   ($urandom % 8 == 0) ? 5'd0 : 5'($urandom),
                   $urandom, $urandom, $urandom, sp,
                   int'($urandom % 4), $urandom, ($urandom % 8) == 0);
        end
        finish_run();
    end

endmodule